// File: doc/BRIEF.md
# DMA Channel Request Generator

This block decides, cycle by cycle, which of six DMA channels may use the bus next. Each channel has a 4-bit source select that chooses where its requests come from. A channel can request on its own (auto). It can follow an external request pin, which exists on channels 0 to 3 only. Or it can follow one of eight on-chip peripheral request strobes. Requests pass only while the global and per-channel enable conditions hold.

On channels 0 to 3, the external pins first pass through a two-flop synchronizer. Each of these channels then detects its pin by level or by edge, with a polarity of its own choosing. Strobes and detected edges are held in a sticky pending bit. A fixed-priority arbiter grants one channel per cycle, with channel 0 highest. A channel in cycle-steal mode gives up the grant after each transfer. A channel in burst mode keeps the grant for as long as its request stands.

The surrounding controller drives the control inputs from its registers, performs the transfer for the granted channel, and sets the transfer-end flag when it is done.

Top module: `dma_req_gen`

## Requirements
- R1: A channel can request only while its enable is 1, its transfer-end flag is 0, the global master enable is 1, and both the address-error and NMI flags are 0. Dropping any one of these withdraws the request and clears its pending bit.
- R2: Source select 4'b0100 is auto-request. The channel requests on every cycle its gate (R1) is open, and the grant appears on the clock edge after the gate opens.
- R3: Source select 4'b0000 on channels 0 to 3 selects the external pin. With detect-edge 0 (level mode), the request follows the synchronized pin: active high when polarity is 1, active low when polarity is 0. The grant follows a pin change by three clock edges.
- R4: With detect-edge 1 on channels 0 to 3, a rising pin edge (polarity 1) or a falling pin edge (polarity 0) sets the pending bit. The first grant follows the pin change by four clock edges. The opposite edge does nothing.
- R5: Channels 4 and 5 have no external pin. On these channels, source select 4'b0000 never produces a request, whatever the pins do.
- R6: A source select of the form 4'b1sss selects peripheral strobe sss. A one-cycle strobe sets the pending bit, and the grant appears two clock edges after the strobe. Strobes at other indices have no effect on that channel.
- R7: At most one grant is active in any cycle. Among the requesting channels, the lowest-numbered one wins. grant_onehot bit grant_id is the only bit set while grant_valid is 1, and grant_onehot is zero while grant_valid is 0.
- R8: In cycle-steal mode (burst 0), a grant clears the pending bit it served. One edge or one strobe yields exactly one grant cycle.
- R9: In burst mode (burst 1), a granted channel keeps the grant while its request stands, even against higher-priority requests. Once its gate closes, arbitration resumes on the next edge.
- R10: Every source select code not named in R2, R3 or R6 produces no request.
- R11: While reset is high, grant_valid is 0, grant_onehot is 0 and all pending bits are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| glb_master_en | input | 1 | Global master enable |
| glb_addr_err | input | 1 | Global address-error flag; blocks all requests |
| glb_nmi | input | 1 | Global NMI flag; blocks all requests |
| ch_enable | input | 6 | Per-channel enable |
| ch_end | input | 6 | Per-channel transfer-end flag |
| ch_src_sel | input | 24 | Per-channel 4-bit source select, channel n at bits [4n+3:4n] |
| ch_burst | input | 6 | 1 = burst mode, 0 = cycle-steal mode |
| ext_det_edge | input | 4 | Channels 0 to 3: 1 = edge detection, 0 = level detection |
| ext_det_high | input | 4 | Channels 0 to 3: 1 = high level / rising edge, 0 = low level / falling edge |
| ext_req_pin | input | 4 | Asynchronous external request pins for channels 0 to 3 |
| periph_strobe | input | 8 | On-chip peripheral request strobes |
| grant_valid | output | 1 | A channel is granted this cycle |
| grant_id | output | 3 | Index of the granted channel |
| grant_onehot | output | 6 | One-hot form of the granted channel |

## Verification
The gating assertions assume that the control inputs are quasi-static register values, which change only between clock edges. The stimulus always changes them just after a falling edge. The checks on channels 4 and 5 assume that the controller sees an external selection on those channels as inert. The directed scenarios enable only the channels they exercise, and they let the pins settle through the synchronizer before they enable a channel, so no stale pin state produces an early grant.

// File: rtl/dmareq_pkg.sv
package dmareq_pkg;

    localparam int SEL_W      = 4;
    localparam int PER_IDX_W  = SEL_W - 1;

    localparam logic [SEL_W-1:0] SEL_EXT  = 4'b0000;
    localparam logic [SEL_W-1:0] SEL_AUTO = 4'b0100;

    typedef logic [SEL_W-1:0] src_sel_t;

    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_AUTO   = 2'd1,
        SRC_EXT    = 2'd2,
        SRC_PERIPH = 2'd3
    } src_kind_e;

    typedef struct packed {
        logic level_act;
        logic edge_evt;
    } ext_sense_t;

    function automatic src_kind_e decode_src(input src_sel_t sel, input logic ext_ok);
        src_kind_e k;
        if (sel[SEL_W-1])
            k = SRC_PERIPH;
        else if (sel == SEL_AUTO)
            k = SRC_AUTO;
        else if (sel == SEL_EXT && ext_ok)
            k = SRC_EXT;
        else
            k = SRC_NONE;
        return k;
    endfunction

    function automatic logic [PER_IDX_W-1:0] periph_index(input src_sel_t sel);
        return sel[PER_IDX_W-1:0];
    endfunction

endpackage

// File: rtl/dmareq_ext_sense.sv
module dmareq_ext_sense
    import dmareq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pin,
    input  logic       det_high,
    output ext_sense_t sense
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign cur = sync_q[SYNC_STAGES-1];

    always_comb begin
        sense.level_act = det_high ? cur : ~cur;
        sense.edge_evt  = det_high ? (cur & ~prev_q) : (~cur & prev_q);
    end

endmodule

// File: rtl/dmareq_chan.sv
module dmareq_chan
    import dmareq_pkg::*;
#(
    parameter int NUM_PER = 8,
    parameter bit HAS_EXT = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               gate,
    input  src_sel_t           src_sel,
    input  logic               det_edge,
    input  ext_sense_t         sense,
    input  logic [NUM_PER-1:0] periph_strobe,
    input  logic               burst,
    input  logic               won,
    output logic               req
);
    src_kind_e kind;
    logic      live;
    logic      evt;
    logic      pend_q;

    always_comb begin
        kind = decode_src(src_sel, HAS_EXT);
        live = 1'b0;
        evt  = 1'b0;
        unique case (kind)
            SRC_AUTO:   live = 1'b1;
            SRC_EXT: begin
                if (det_edge) evt  = sense.edge_evt;
                else          live = sense.level_act;
            end
            SRC_PERIPH: evt = periph_strobe[periph_index(src_sel)];
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            pend_q <= 1'b0;
        else if (!gate)
            pend_q <= 1'b0;
        else if (evt)
            pend_q <= 1'b1;
        else if (won && !burst)
            pend_q <= 1'b0;
    end

    assign req = gate & (live | pend_q);

endmodule

// File: rtl/dmareq_arb.sv
module dmareq_arb #(
    parameter int NUM_CH = 6,
    localparam int ID_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] req,
    input  logic [NUM_CH-1:0] burst,
    output logic [NUM_CH-1:0] win,
    output logic              gnt_valid,
    output logic [ID_W-1:0]   gnt_id,
    output logic [NUM_CH-1:0] gnt_onehot
);
    logic [NUM_CH-1:0] pri_win;
    logic [NUM_CH-1:0] lock_mask;
    logic              lock_q;
    logic [ID_W-1:0]   lock_id_q;
    logic              hold;
    logic [ID_W-1:0]   win_id;

    always_comb begin
        pri_win = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (req[i]) pri_win = NUM_CH'(1) << i;
        end
    end

    always_comb begin
        lock_mask = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (lock_id_q == ID_W'(i)) lock_mask[i] = 1'b1;
        end
        hold = lock_q && |(req & lock_mask);
        win  = hold ? lock_mask : pri_win;
    end

    always_comb begin
        win_id = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (win[i]) win_id = win_id | ID_W'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gnt_valid  <= 1'b0;
            gnt_id     <= '0;
            gnt_onehot <= '0;
            lock_q     <= 1'b0;
            lock_id_q  <= '0;
        end else begin
            gnt_valid  <= |win;
            gnt_id     <= win_id;
            gnt_onehot <= win;
            lock_q     <= |(win & burst);
            lock_id_q  <= win_id;
        end
    end

endmodule

// File: rtl/dma_req_gen.sv
module dma_req_gen
    import dmareq_pkg::*;
#(
    parameter int NUM_CH   = 6,
    parameter int NUM_EXT  = 4,
    parameter int NUM_PER  = 8,
    localparam int ID_W    = $clog2(NUM_CH)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    glb_master_en,
    input  logic                    glb_addr_err,
    input  logic                    glb_nmi,
    input  logic [NUM_CH-1:0]       ch_enable,
    input  logic [NUM_CH-1:0]       ch_end,
    input  logic [NUM_CH*SEL_W-1:0] ch_src_sel,
    input  logic [NUM_CH-1:0]       ch_burst,
    input  logic [NUM_EXT-1:0]      ext_det_edge,
    input  logic [NUM_EXT-1:0]      ext_det_high,
    input  logic [NUM_EXT-1:0]      ext_req_pin,
    input  logic [NUM_PER-1:0]      periph_strobe,
    output logic                    grant_valid,
    output logic [ID_W-1:0]         grant_id,
    output logic [NUM_CH-1:0]       grant_onehot
);
    logic              glb_ok;
    logic [NUM_CH-1:0] gate;
    logic [NUM_CH-1:0] req;
    logic [NUM_CH-1:0] win;

    assign glb_ok = glb_master_en & ~glb_addr_err & ~glb_nmi;
    assign gate   = {NUM_CH{glb_ok}} & ch_enable & ~ch_end;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        ext_sense_t sense;
        logic       det_edge;

        if (c < NUM_EXT) begin : g_ext
            dmareq_ext_sense u_sense (
                .clk      (clk),
                .rst      (rst),
                .pin      (ext_req_pin[c]),
                .det_high (ext_det_high[c]),
                .sense    (sense)
            );
            assign det_edge = ext_det_edge[c];
        end else begin : g_noext
            assign sense    = '0;
            assign det_edge = 1'b0;
        end

        dmareq_chan #(
            .NUM_PER (NUM_PER),
            .HAS_EXT (c < NUM_EXT)
        ) u_chan (
            .clk           (clk),
            .rst           (rst),
            .gate          (gate[c]),
            .src_sel       (ch_src_sel[c*SEL_W +: SEL_W]),
            .det_edge      (det_edge),
            .sense         (sense),
            .periph_strobe (periph_strobe),
            .burst         (ch_burst[c]),
            .won           (win[c]),
            .req           (req[c])
        );
    end

    dmareq_arb #(.NUM_CH(NUM_CH)) u_arb (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .burst      (ch_burst),
        .win        (win),
        .gnt_valid  (grant_valid),
        .gnt_id     (grant_id),
        .gnt_onehot (grant_onehot)
    );

endmodule

// File: rtl/dma_req_gen_chk.sv
module dma_req_gen_chk
    import dmareq_pkg::*;
#(
    parameter int NUM_CH  = 6,
    parameter int NUM_EXT = 4,
    localparam int ID_W   = $clog2(NUM_CH)
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    glb_master_en,
    input logic                    glb_addr_err,
    input logic                    glb_nmi,
    input logic [NUM_CH-1:0]       ch_enable,
    input logic [NUM_CH-1:0]       ch_end,
    input logic [NUM_CH*SEL_W-1:0] ch_src_sel,
    input logic                    grant_valid,
    input logic [ID_W-1:0]         grant_id,
    input logic [NUM_CH-1:0]       grant_onehot
);
    // R7
    single_grant_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_onehot));

    // R7
    id_match_chk: assert property (@(posedge clk) disable iff (rst)
        grant_valid |-> grant_onehot[grant_id]);

    // R7
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !grant_valid |-> (grant_onehot == '0));

    // R1
    global_gate_chk: assert property (@(posedge clk) disable iff (rst)
        grant_valid |-> $past(glb_master_en && !glb_addr_err && !glb_nmi));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_c
        // R1
        chan_gate_chk: assert property (@(posedge clk) disable iff (rst)
            grant_onehot[c] |-> $past(ch_enable[c] && !ch_end[c]));

        if (c >= NUM_EXT) begin : g_noext
            // R5
            no_ext_chk: assert property (@(posedge clk) disable iff (rst)
                grant_onehot[c] |-> $past(ch_src_sel[c*SEL_W +: SEL_W] != SEL_EXT));
        end
    end

endmodule

bind dma_req_gen dma_req_gen_chk #(.NUM_CH(NUM_CH), .NUM_EXT(NUM_EXT)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .glb_master_en (glb_master_en),
    .glb_addr_err  (glb_addr_err),
    .glb_nmi       (glb_nmi),
    .ch_enable     (ch_enable),
    .ch_end        (ch_end),
    .ch_src_sel    (ch_src_sel),
    .grant_valid   (grant_valid),
    .grant_id      (grant_id),
    .grant_onehot  (grant_onehot)
);

// File: tb/sim_dma_req_gen.sv
module sim_dma_req_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        glb_master_en, glb_addr_err, glb_nmi;
    logic [5:0]  ch_enable, ch_end, ch_burst;
    logic [23:0] ch_src_sel;
    logic [3:0]  ext_det_edge, ext_det_high, ext_req_pin;
    logic [7:0]  periph_strobe;
    logic        grant_valid;
    logic [2:0]  grant_id;
    logic [5:0]  grant_onehot;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    dma_req_gen u0 (
        .clk(clk), .rst(rst),
        .glb_master_en(glb_master_en), .glb_addr_err(glb_addr_err), .glb_nmi(glb_nmi),
        .ch_enable(ch_enable), .ch_end(ch_end), .ch_src_sel(ch_src_sel),
        .ch_burst(ch_burst), .ext_det_edge(ext_det_edge), .ext_det_high(ext_det_high),
        .ext_req_pin(ext_req_pin), .periph_strobe(periph_strobe),
        .grant_valid(grant_valid), .grant_id(grant_id), .grant_onehot(grant_onehot)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_grant(input string req, input logic v, input logic [2:0] id);
        logic [5:0] oh;
        oh = v ? (6'd1 << id) : 6'd0;
        tests++;
        if (grant_valid !== v || grant_onehot !== oh || (v && grant_id !== id)) begin
            fails++;
            $display("FAIL %s: valid=%0b id=%0d onehot=%b expected valid=%0b id=%0d onehot=%b",
                     req, grant_valid, grant_id, grant_onehot, v, id, oh);
        end
    endtask

    task automatic set_sel(input int ch, input logic [3:0] v);
        ch_src_sel[ch*4 +: 4] = v;
    endtask

    task automatic quiet();
        glb_master_en = 1'b1; glb_addr_err = 1'b0; glb_nmi = 1'b0;
        ch_enable = '0; ch_end = '0; ch_burst = '0; ch_src_sel = {6{4'b0110}};
        ext_det_edge = '0; ext_det_high = '0; ext_req_pin = '0; periph_strobe = '0;
        tick(4);
    endtask

    task automatic t_reset();
        expect_grant("R11 reset", 1'b0, 3'd0);
    endtask

    task automatic t_auto_gate();
        quiet();
        set_sel(2, 4'b0100); ch_enable[2] = 1'b1;
        tick(1); expect_grant("R2 auto first edge", 1'b1, 3'd2);
        tick(1); expect_grant("R2 auto continues", 1'b1, 3'd2);
        for (int k = 0; k < 5; k++) begin
            case (k)
                0: glb_master_en = 1'b0;
                1: glb_addr_err  = 1'b1;
                2: glb_nmi       = 1'b1;
                3: ch_enable[2]  = 1'b0;
                default: ch_end[2] = 1'b1;
            endcase
            tick(1); expect_grant("R1 gate closed", 1'b0, 3'd0);
            glb_master_en = 1'b1; glb_addr_err = 1'b0; glb_nmi = 1'b0;
            ch_enable[2] = 1'b1; ch_end[2] = 1'b0;
            tick(1); expect_grant("R1 gate reopened", 1'b1, 3'd2);
        end
    endtask

    task automatic t_priority();
        quiet();
        set_sel(1, 4'b0100); set_sel(3, 4'b0100); set_sel(5, 4'b0100);
        ch_enable = 6'b101010;
        tick(1); expect_grant("R7 lowest index wins", 1'b1, 3'd1);
        ch_enable[1] = 1'b0;
        tick(1); expect_grant("R7 next channel", 1'b1, 3'd3);
        ch_enable[3] = 1'b0;
        tick(1); expect_grant("R7 last channel", 1'b1, 3'd5);
    endtask

    task automatic t_level();
        quiet();
        set_sel(0, 4'b0000); ext_det_high[0] = 1'b1; ch_enable[0] = 1'b1;
        ext_req_pin[0] = 1'b1;
        tick(2); expect_grant("R3 level not yet", 1'b0, 3'd0);
        tick(1); expect_grant("R3 level high", 1'b1, 3'd0);
        ext_req_pin[0] = 1'b0;
        tick(2); expect_grant("R3 level held", 1'b1, 3'd0);
        tick(1); expect_grant("R3 level release", 1'b0, 3'd0);
        quiet();
        ext_req_pin[1] = 1'b1; tick(4);
        set_sel(1, 4'b0000); ch_enable[1] = 1'b1;
        tick(3); expect_grant("R3 active-low idle", 1'b0, 3'd0);
        ext_req_pin[1] = 1'b0;
        tick(3); expect_grant("R3 active-low asserted", 1'b1, 3'd1);
    endtask

    task automatic t_edge();
        quiet();
        set_sel(2, 4'b0000); ext_det_edge[2] = 1'b1; ext_det_high[2] = 1'b1; ch_enable[2] = 1'b1;
        tick(2);
        ext_req_pin[2] = 1'b1;
        tick(3); expect_grant("R4 rising not yet", 1'b0, 3'd0);
        tick(1); expect_grant("R4 rising edge grant", 1'b1, 3'd2);
        tick(1); expect_grant("R8 edge consumed", 1'b0, 3'd0);
        tick(3); expect_grant("R8 no regrant while high", 1'b0, 3'd0);
        ext_req_pin[2] = 1'b0;
        tick(6); expect_grant("R4 falling ignored", 1'b0, 3'd0);
        quiet();
        ext_req_pin[3] = 1'b1; tick(4);
        set_sel(3, 4'b0000); ext_det_edge[3] = 1'b1; ch_enable[3] = 1'b1;
        tick(2); expect_grant("R4 idle high no edge", 1'b0, 3'd0);
        ext_req_pin[3] = 1'b0;
        tick(4); expect_grant("R4 falling edge grant", 1'b1, 3'd3);
        tick(1); expect_grant("R8 falling consumed", 1'b0, 3'd0);
    endtask

    task automatic t_no_ext();
        quiet();
        set_sel(4, 4'b0000); set_sel(5, 4'b0000); ch_enable = 6'b110000;
        ext_det_high = 4'hF;
        for (int k = 0; k < 4; k++) begin
            ext_req_pin = (k % 2 == 0) ? 4'hF : 4'h0;
            tick(3); expect_grant("R5 ch4/5 ignore pins", 1'b0, 3'd0);
        end
    endtask

    task automatic t_periph();
        quiet();
        set_sel(5, 4'b1011); ch_enable[5] = 1'b1;
        periph_strobe[2] = 1'b1; tick(1); periph_strobe = '0;
        tick(2); expect_grant("R6 other index ignored", 1'b0, 3'd0);
        periph_strobe[3] = 1'b1; tick(1); periph_strobe = '0;
        expect_grant("R6 pending set", 1'b0, 3'd0);
        tick(1); expect_grant("R6 strobe grant", 1'b1, 3'd5);
        tick(1); expect_grant("R8 strobe consumed", 1'b0, 3'd0);
    endtask

    task automatic t_reserved();
        quiet();
        set_sel(0, 4'b0101); set_sel(4, 4'b0010); ch_enable = 6'b010001;
        ext_det_high[0] = 1'b1; ext_req_pin[0] = 1'b1; periph_strobe = 8'hFF;
        tick(4); expect_grant("R10 reserved code", 1'b0, 3'd0);
        periph_strobe = '0;
        tick(2); expect_grant("R10 reserved after strobes", 1'b0, 3'd0);
    endtask

    task automatic t_burst();
        quiet();
        set_sel(3, 4'b0100); ch_burst[3] = 1'b1; ch_enable[3] = 1'b1;
        tick(1); expect_grant("R9 burst granted", 1'b1, 3'd3);
        set_sel(0, 4'b0100); ch_enable[0] = 1'b1;
        tick(1); expect_grant("R9 burst holds vs ch0", 1'b1, 3'd3);
        tick(3); expect_grant("R9 burst still held", 1'b1, 3'd3);
        ch_end[3] = 1'b1;
        tick(1); expect_grant("R9 release on end flag", 1'b1, 3'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        glb_master_en = 1'b1; glb_addr_err = 1'b0; glb_nmi = 1'b0;
        ch_enable = 6'b111111; ch_end = '0; ch_burst = '0; ch_src_sel = {6{4'b0100}};
        ext_det_edge = '0; ext_det_high = '0; ext_req_pin = '0; periph_strobe = 8'hFF;
        tick(3);
        t_reset();
        ch_enable = '0; periph_strobe = '0;
        rst = 1'b0;
        tick(1);
        t_reset();
        t_auto_gate();
        t_priority();
        t_level();
        t_edge();
        t_no_ext();
        t_periph();
        t_reserved();
        t_burst();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule